// File: doc/BRIEF.md
# Pointer-Addressed Byte RAM Window

This block gives a host access to a general-purpose byte RAM of 512 locations through four byte-wide registers instead of a flat memory map. The host first loads a 9-bit location pointer through two pointer registers. The register holding the upper bit must be written before the register holding the lower eight bits. The host then moves data through a data-in register, which stores bytes, or a data-out register, which fetches bytes.

Each data access moves the pointer on by one location, so a burst of bytes sent to the same register walks through consecutive locations. When the pointer passes the last location it returns to zero. The register port is a simple synchronous byte interface with separate write and read strobes. Read results appear on the registered `rdData` output one clock after the read strobe.

Top module: `nvram_window`

## Requirements
- R1: After the active-low asynchronous reset, `rdData` is 0 and the location pointer is 0. Reading the two pointer registers returns 0.
- R2: A write to offset 0x1A loads pointer bit 8 from `wrData[0]` and ignores the other seven bits. A write to offset 0x1B loads pointer bits 7:0. A read of 0x1A returns `{7'b0, pointer[8]}` and a read of 0x1B returns `pointer[7:0]`, in each case on `rdData` one clock later.
- R3: A write to offset 0x1C stores `wrData` at the location the pointer names, then advances the pointer by one.
- R4: A read of offset 0x1D places the byte at the pointer location on `rdData` on the next clock, then advances the pointer by one.
- R5: Advancing the pointer from location 511 gives location 0, for both stores and fetches, so bursts wrap around.
- R6: Writes to the pointer registers leave every RAM location unchanged.
- R7: The following accesses neither store data nor move the pointer: a write to 0x1D, a read of 0x1C, and any access to another offset. `rdData` is 0 in the clock after any cycle that is not a read of 0x1A, 0x1B or 0x1D.
- R8: When `wrEn` and `rdEn` are both high, only the write is carried out. The read is dropped and `rdData` is 0 in the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regSel | input | 5 | Register offset of the access |
| wrEn | input | 1 | Write strobe for the selected register |
| wrData | input | 8 | Byte to write |
| rdEn | input | 1 | Read strobe for the selected register |
| rdData | output | 8 | Registered read result, valid the clock after `rdEn` |

## Verification
The bench checks bursts that cross the 511-to-0 boundary in both directions. A wrong wrap would either fetch from beyond the array or leave the pointer stuck at the top location. It writes the upper pointer register with stray high bits set, which catches a decoder that keeps more than bit 0. It also reprograms the pointer repeatedly and then re-reads the RAM, which exposes a store path that fires on pointer writes. Finally, it issues wrong-direction accesses and simultaneous strobes to the data registers. These cases expose a pointer that advances on any access to the window, and a read that is not suppressed under a concurrent write.

// File: rtl/nvram_pkg.sv
package nvram_pkg;
  // strobes sent by the decoder to the datapath
  typedef struct packed {
    logic loadHi;
    logic loadLo;
    logic memWr;
    logic memRd;
    logic rdHi;
    logic rdLo;
  } nvramStrobes_t;
endpackage

// File: rtl/nvram_ctrl.sv
module nvram_ctrl
  import nvram_pkg::*;
#(
  parameter int SEL_W = 5,
  parameter logic [SEL_W-1:0] PTR_HI_OFS = 5'h1A,
  parameter logic [SEL_W-1:0] PTR_LO_OFS = 5'h1B,
  parameter logic [SEL_W-1:0] WR_PORT_OFS = 5'h1C,
  parameter logic [SEL_W-1:0] RD_PORT_OFS = 5'h1D
) (
  input  logic [SEL_W-1:0] regSel,
  input  logic             wrEn,
  input  logic             rdEn,
  output nvramStrobes_t    strobes
);
  logic rdOnly;

  // a write always wins; a read only counts when no write is present
  assign rdOnly = rdEn && !wrEn;

  always_comb begin
    strobes.loadHi = wrEn && (regSel == PTR_HI_OFS);
    strobes.loadLo = wrEn && (regSel == PTR_LO_OFS);
    strobes.memWr  = wrEn && (regSel == WR_PORT_OFS);
    strobes.memRd  = rdOnly && (regSel == RD_PORT_OFS);
    strobes.rdHi   = rdOnly && (regSel == PTR_HI_OFS);
    strobes.rdLo   = rdOnly && (regSel == PTR_LO_OFS);
  end
endmodule

// File: rtl/nvram_dpath.sv
module nvram_dpath
  import nvram_pkg::*;
#(
  parameter int DEPTH = 512,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int HI_W = ADDR_W - 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  nvramStrobes_t     strobes,
  input  logic [7:0]        wrData,
  output logic [7:0]        rdData,
  output logic [ADDR_W-1:0] ptrVal
);
  logic [7:0]        mem [DEPTH];
  logic [ADDR_W-1:0] ptrNext;
  logic [ADDR_W-1:0] ptrInc;
  logic              stepPtr;

  assign stepPtr = strobes.memWr || strobes.memRd;
  assign ptrInc  = (ptrVal == ADDR_W'(DEPTH - 1)) ? '0 : ptrVal + 1'b1;

  always_comb begin
    ptrNext = ptrVal;
    if (strobes.loadHi) ptrNext[ADDR_W-1:8] = wrData[HI_W-1:0];
    if (strobes.loadLo) ptrNext[7:0] = wrData;
    if (stepPtr) ptrNext = ptrInc;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ptrVal <= '0;
    else       ptrVal <= ptrNext;
  end

  // storage array carries no reset
  always_ff @(posedge clk) begin
    if (strobes.memWr) mem[ptrVal] <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData <= '0;
    end else if (strobes.memRd) begin
      rdData <= mem[ptrVal];
    end else if (strobes.rdHi) begin
      rdData <= 8'(ptrVal[ADDR_W-1:8]);
    end else if (strobes.rdLo) begin
      rdData <= ptrVal[7:0];
    end else begin
      rdData <= '0;
    end
  end
endmodule

// File: rtl/nvram_window.sv
module nvram_window
  import nvram_pkg::*;
#(
  parameter int DEPTH = 512,
  parameter int SEL_W = 5,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [SEL_W-1:0] regSel,
  input  logic             wrEn,
  input  logic [7:0]       wrData,
  input  logic             rdEn,
  output logic [7:0]       rdData
);
  nvramStrobes_t     strobes;
  logic [ADDR_W-1:0] ptrVal;

  nvram_ctrl #(.SEL_W(SEL_W)) u_ctrl (
    .regSel (regSel),
    .wrEn   (wrEn),
    .rdEn   (rdEn),
    .strobes(strobes)
  );

  nvram_dpath #(.DEPTH(DEPTH)) u_dpath (
    .clk    (clk),
    .rstN   (rstN),
    .strobes(strobes),
    .wrData (wrData),
    .rdData (rdData),
    .ptrVal (ptrVal)
  );
endmodule

// File: rtl/nvram_window_chk.sv
module nvram_window_chk #(
  parameter int SEL_W = 5,
  parameter int ADDR_W = 9
) (
  input logic              clk,
  input logic              rstN,
  input logic [SEL_W-1:0]  regSel,
  input logic              wrEn,
  input logic [7:0]        wrData,
  input logic              rdEn,
  input logic [7:0]        rdData,
  input logic [ADDR_W-1:0] ptrVal
);
  localparam logic [SEL_W-1:0] HI = 5'h1A;
  localparam logic [SEL_W-1:0] LO = 5'h1B;
  localparam logic [SEL_W-1:0] WP = 5'h1C;
  localparam logic [SEL_W-1:0] RP = 5'h1D;

  // R3 and R5: a store moves the pointer on by one, modulo the depth
  p_store_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && regSel == WP) |=> (ptrVal == ADDR_W'($past(ptrVal) + 1'b1)));

  // R4 and R5: a fetch moves the pointer on by one, modulo the depth
  p_fetch_step_r4: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && !wrEn && regSel == RP) |=> (ptrVal == ADDR_W'($past(ptrVal) + 1'b1)));

  p_hi_load_r2: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && regSel == HI) |=>
      (ptrVal[ADDR_W-1] == $past(wrData[0]) && ptrVal[7:0] == $past(ptrVal[7:0])));

  p_ptr_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!(wrEn && (regSel == HI || regSel == LO || regSel == WP)) &&
     !(rdEn && !wrEn && regSel == RP)) |=> $stable(ptrVal));

  p_idle_zero_r7: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |=> (rdData == 8'h00));

  p_write_wins_r8: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && rdEn) |=> (rdData == 8'h00));
endmodule

bind nvram_window nvram_window_chk #(.SEL_W(SEL_W), .ADDR_W(ADDR_W)) u_chk (
  .clk   (clk),
  .rstN  (rstN),
  .regSel(regSel),
  .wrEn  (wrEn),
  .wrData(wrData),
  .rdEn  (rdEn),
  .rdData(rdData),
  .ptrVal(ptrVal)
);

// File: tb/test_nvram_window.sv
module test_nvram_window;
  localparam logic [4:0] HI = 5'h1A;
  localparam logic [4:0] LO = 5'h1B;
  localparam logic [4:0] WP = 5'h1C;
  localparam logic [4:0] RP = 5'h1D;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [4:0] regSel = '0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = '0;
  logic       rdEn = 1'b0;
  logic [7:0] rdData;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  // behavioural reference state
  int refPtr = 0;
  int refMem [512];

  always #5 clk = ~clk;

  nvram_window i_nvram_window (
    .clk(clk), .rstN(rstN), .regSel(regSel), .wrEn(wrEn),
    .wrData(wrData), .rdEn(rdEn), .rdData(rdData)
  );

  task automatic step(input bit we, input bit re, input logic [4:0] sel,
                      input int wd, input string tag);
    int expRd;
    expRd = 0;
    regSel = sel; wrEn = we; rdEn = re; wrData = 8'(wd);
    if (we) begin
      if (sel == HI) refPtr = (refPtr & 255) | ((wd & 1) << 8);
      else if (sel == LO) refPtr = (refPtr & 256) | (wd & 255);
      else if (sel == WP) begin
        refMem[refPtr] = wd & 255;
        refPtr = (refPtr + 1) % 512;
      end
    end else if (re) begin
      if (sel == RP) begin
        expRd = refMem[refPtr];
        refPtr = (refPtr + 1) % 512;
      end else if (sel == HI) expRd = refPtr >> 8;
      else if (sel == LO) expRd = refPtr & 255;
    end
    @(negedge clk);
    checks++;
    if (int'(rdData) != expRd) begin
      errors++;
      $display("FAIL %s: rdData actual=%0h expected=%0h", tag, rdData, expRd);
    end
  endtask

  task automatic idle(input string tag);
    step(0, 0, 5'h00, 0, tag);
  endtask

  task automatic readPtr(input string tag);
    step(0, 1, HI, 0, tag);
    step(0, 1, LO, 0, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: reset state
    checks++;
    if (rdData != 8'h00) begin
      errors++;
      $display("FAIL R1: rdData actual=%0h expected=0", rdData);
    end
    readPtr("R1");
    // R3 with R5: fill the whole array, pointer wraps back to 0
    for (int i = 0; i < 512; i++) step(1, 0, WP, (i * 7 + 3) & 255, "R3");
    readPtr("R5");
    // R2: stray high bits in the upper pointer byte are dropped
    step(1, 0, HI, 8'hFF, "R2");
    step(1, 0, LO, 8'hF0, "R2");
    readPtr("R2");
    // R4 and R5: fetch burst across the top of the array
    for (int i = 0; i < 24; i++) step(0, 1, RP, 0, "R4");
    readPtr("R5");
    // R5: store burst across the top of the array
    step(1, 0, HI, 1, "R5");
    step(1, 0, LO, 8'hFD, "R5");
    for (int i = 0; i < 6; i++) step(1, 0, WP, 8'hA0 + i, "R5");
    readPtr("R5");
    // R6: pointer writes leave contents alone
    for (int i = 0; i < 8; i++) begin
      step(1, 0, HI, i, "R6");
      step(1, 0, LO, i * 33, "R6");
    end
    step(1, 0, HI, 1, "R6");
    step(1, 0, LO, 8'hFA, "R6");
    for (int i = 0; i < 12; i++) step(0, 1, RP, 0, "R6");
    step(1, 0, HI, 0, "R6");
    step(1, 0, LO, 0, "R6");
    for (int i = 0; i < 10; i++) step(0, 1, RP, 0, "R6");
    // R7: wrong-direction and unmapped accesses
    step(1, 0, LO, 8'h40, "R7");
    step(1, 0, RP, 8'h55, "R7");
    step(0, 1, WP, 0, "R7");
    step(1, 0, 5'h05, 8'h77, "R7");
    step(0, 1, 5'h05, 0, "R7");
    idle("R7");
    readPtr("R7");
    step(0, 1, RP, 0, "R7");
    // R8: both strobes high
    step(1, 1, WP, 8'h99, "R8");
    step(1, 1, RP, 8'h11, "R8");
    step(1, 1, LO, 8'h41, "R8");
    readPtr("R8");
    step(0, 1, RP, 0, "R8");
    step(1, 0, LO, 8'h41, "R8");
    step(0, 1, RP, 0, "R8");
    idle("R7");
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule